// File: doc/BRIEF.md
# LIN Frame Command Engine

This block runs one LIN frame per command. Software sets up the frame identifier, the number of bytes to send, the number of bytes to receive and the checksum flavour. It loads any outgoing data into a small transmit queue and then pulses a doorbell. As bus master the engine sends the frame header: a break symbol, the sync byte and the protected identifier. It then either sends the response bytes followed by their checksum, or collects the response bytes and checks their checksum. As a slave the engine watches for a header, checks the identifier parity and holds the received identifier. A later doorbell answers that header with a response and sends no header of its own.

The bit-level serialiser sits outside the block and meets it at a byte-strobe interface. Outgoing symbols use a valid/ready handshake, and the serialiser may stall by holding `ser_tx_ready` low. When `ser_tx_brk` is high the symbol is a break, and the data byte gives its length in bit times. Incoming bytes arrive as single-cycle strobes and cannot be stalled. The transmit queue input and the receive queue output are valid/ready streams. A word moves only on a cycle where both valid and ready are high, and valid never depends on ready. Events are collected in sticky flags, and each flag has an enable into one combined interrupt.

Flag bit positions: 0 command done, 1 command abort, 2 checksum pass, 3 checksum error, 4 identifier pass, 5 identifier error, 6 command rejected.

Top module: `lin_cmd_engine`

## Requirements
- R1: The protected identifier byte holds the 6-bit identifier in bits 5:0, id0^id1^id2^id4 in bit 6, and the inverse of id1^id3^id4^id5 in bit 7.
- R2: A doorbell whose transmit count or receive count exceeds 8, or whose two counts are both nonzero, sets flag 6, and no symbol is sent.
- R3: In master mode a doorbell sends, in order, a break symbol (`ser_tx_brk`=1, data = the larger of `cfg_brk_len` and 13), then 0x55, then the protected identifier.
- R4: A master transmit command sends the queued bytes in push order and then the checksum byte. Flag 0 is set once the serialiser accepts the checksum.
- R5: The checksum is the inverse of the 8-bit sum with end-around carry. The classic flavour sums the data only. The enhanced flavour also adds the protected identifier, except for identifiers 0x3C and 0x3D, which always use the classic flavour.
- R6: A receive command places each received data byte in the receive queue. The byte after the last data byte is compared with the expected checksum: a match sets flag 2 and a mismatch sets flag 3.
- R7: With a nonzero `cfg_timeout`, a command still busy after that many cycles sets flag 1 and returns the engine to idle. The value 0 disables the timeout.
- R8: In slave mode a break strobe, then 0x55, then a byte with correct parity sets flag 4 and updates `rx_id`. Wrong parity sets flag 5 and leaves `rx_id` unchanged. A sync byte other than 0x55 drops the header and sets no flag.
- R9: In master mode received break strobes are ignored, and no identifier flag results.
- R10: In slave mode a doorbell skips the header and sends the response at once. The enhanced checksum then uses the identifier held in `rx_id`.
- R11: Flags stay set until a 1 is written to the matching bit of `flag_clr`. `irq` is high when any flag with a set enable bit is high.
- R12: `tx_fifo_clr` and `rx_fifo_clr` empty their queues, and `soft_rst` clears every flag and returns the engine to idle.
- R13: A master command with both counts zero sends the header only and sets flag 0 after the identifier is accepted.
- R14: The transmit queue holds `FIFO_DEPTH` bytes, and `txq_ready` is low while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| soft_rst | input | 1 | one-cycle module reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_enhanced | input | 1 | 1 = enhanced checksum |
| cfg_id | input | 6 | frame identifier (master) |
| cfg_tx_cnt | input | 4 | bytes to send |
| cfg_rx_cnt | input | 4 | bytes to receive |
| cfg_brk_len | input | 5 | break length in bit times |
| cfg_timeout | input | TO_W | busy-cycle limit, 0 = off |
| doorbell | input | 1 | start pulse |
| tx_fifo_clr | input | 1 | empty transmit queue |
| rx_fifo_clr | input | 1 | empty receive queue |
| txq_valid | input | 1 | transmit byte valid |
| txq_ready | output | 1 | transmit queue has room |
| txq_data | input | 8 | transmit byte |
| rxq_valid | output | 1 | received byte available |
| rxq_ready | input | 1 | consumer takes byte |
| rxq_data | output | 8 | received byte |
| ser_tx_valid | output | 1 | symbol to serialiser valid |
| ser_tx_ready | input | 1 | serialiser accepts symbol |
| ser_tx_brk | output | 1 | symbol is a break |
| ser_tx_data | output | 8 | byte, or break length |
| ser_rx_valid | input | 1 | received byte strobe |
| ser_rx_brk | input | 1 | break detected strobe |
| ser_rx_data | input | 8 | received byte |
| irq_en | input | 7 | per-flag interrupt enable |
| flag_clr | input | 7 | write-one-to-clear flags |
| flags | output | 7 | sticky event flags |
| irq | output | 1 | combined interrupt |
| rx_id | output | 6 | identifier from last good header |

## Verification
The assertions assume that whoever drains the receive queue keeps up. A received byte must always find room in the queue, because the serialiser cannot be stalled. The stimulus therefore never starts a receive command while earlier bytes still fill the queue, and it never asks for more than 8 bytes with the default depth of 8. The assertions also assume that `ser_rx_valid` and `ser_rx_brk` are one-cycle strobes. The stimulus drives every received byte as a single-cycle pulse, with idle cycles in between.

// File: rtl/lin_cmd_pkg.sv
package lin_cmd_pkg;
  localparam int NFLAG    = 7;
  localparam int F_DONE   = 0;
  localparam int F_ABORT  = 1;
  localparam int F_CKPASS = 2;
  localparam int F_CKERR  = 3;
  localparam int F_IDPASS = 4;
  localparam int F_IDERR  = 5;
  localparam int F_REJECT = 6;
  localparam int MAX_DATA = 8;
  localparam int MIN_BRK  = 13;
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [5:0] ID_SLEEP  = 6'h3C;
  localparam logic [5:0] ID_WAKE   = 6'h3D;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BRK, ST_SYNC, ST_PID, ST_TXD, ST_TXC,
    ST_RXD, ST_RXC, ST_SSYNC, ST_SPID
  } lin_state_e;

  function automatic logic [7:0] lin_pid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] lin_cks_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction
endpackage

// File: rtl/lin_byte_fifo.sv
module lin_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          wr, rd;

  assign in_ready  = (cnt != FULL_CNT);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign wr = in_valid && in_ready;
  assign rd = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (wr) wp <= (wp == LAST) ? '0 : wp + AW'(1);
      if (rd) rp <= (rp == LAST) ? '0 : rp + AW'(1);
      cnt <= cnt + (AW+1)'(wr) - (AW+1)'(rd);
    end
  end

  assert_fifo_bound_R14: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
endmodule

// File: rtl/lin_frame_fsm.sv
module lin_frame_fsm
  import lin_cmd_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            cfg_master,
  input  logic            cfg_enhanced,
  input  logic [5:0]      cfg_id,
  input  logic [3:0]      cfg_tx_cnt,
  input  logic [3:0]      cfg_rx_cnt,
  input  logic [4:0]      cfg_brk_len,
  input  logic [TO_W-1:0] cfg_timeout,
  input  logic            doorbell,
  input  logic            txf_valid,
  output logic            txf_ready,
  input  logic [7:0]      txf_data,
  output logic            rxf_valid,
  input  logic            rxf_ready,
  output logic [7:0]      rxf_data,
  output logic            ser_tx_valid,
  input  logic            ser_tx_ready,
  output logic            ser_tx_brk,
  output logic [7:0]      ser_tx_data,
  input  logic            ser_rx_valid,
  input  logic            ser_rx_brk,
  input  logic [7:0]      ser_rx_data,
  output logic [5:0]      rx_id,
  output logic [NFLAG-1:0] ev
);
  lin_state_e state, nstate;
  logic [7:0]      sum, nsum, pid, npid;
  logic [3:0]      cnt, ncnt, cmd_tx, ncmd_tx, cmd_rx, ncmd_rx;
  logic [TO_W-1:0] tmr, ntmr;
  logic [5:0]      nrx_id, id_use;
  logic            cmd_bad, hs;
  logic [7:0]      brk_byte;

  assign cmd_bad = (cfg_tx_cnt > 4'(MAX_DATA)) || (cfg_rx_cnt > 4'(MAX_DATA)) ||
                   ((cfg_tx_cnt != '0) && (cfg_rx_cnt != '0));
  assign brk_byte = (cfg_brk_len < 5'(MIN_BRK)) ? 8'(MIN_BRK) : {3'd0, cfg_brk_len};
  assign id_use = cfg_master ? cfg_id : rx_id;

  assign ser_tx_valid = (state == ST_BRK) || (state == ST_SYNC) || (state == ST_PID) ||
                        (state == ST_TXC) || ((state == ST_TXD) && txf_valid);
  assign ser_tx_brk = (state == ST_BRK);
  assign hs = ser_tx_valid && ser_tx_ready;
  assign txf_ready = (state == ST_TXD) && ser_tx_ready;
  assign rxf_valid = (state == ST_RXD) && ser_rx_valid;
  assign rxf_data  = ser_rx_data;

  always_comb begin
    case (state)
      ST_BRK:  ser_tx_data = brk_byte;
      ST_SYNC: ser_tx_data = SYNC_BYTE;
      ST_PID:  ser_tx_data = pid;
      ST_TXD:  ser_tx_data = txf_data;
      ST_TXC:  ser_tx_data = ~sum;
      default: ser_tx_data = 8'h00;
    endcase
  end

  always_comb begin
    nstate = state; nsum = sum; ncnt = cnt; npid = pid;
    ncmd_tx = cmd_tx; ncmd_rx = cmd_rx; nrx_id = rx_id; ev = '0;
    ntmr = (state == ST_IDLE) ? '0 : tmr + TO_W'(1);
    case (state)
      ST_IDLE: begin
        if (doorbell) begin
          if (cmd_bad) ev[F_REJECT] = 1'b1;
          else begin
            ncmd_tx = cfg_tx_cnt; ncmd_rx = cfg_rx_cnt; ncnt = '0;
            npid = lin_pid(id_use);
            nsum = (cfg_enhanced && id_use != ID_SLEEP && id_use != ID_WAKE) ? npid : 8'h00;
            if (cfg_master)               nstate = ST_BRK;
            else if (cfg_tx_cnt != '0)    nstate = ST_TXD;
            else if (cfg_rx_cnt != '0)    nstate = ST_RXD;
            else                          ev[F_DONE] = 1'b1;
          end
        end else if (!cfg_master && ser_rx_brk) nstate = ST_SSYNC;
      end
      ST_BRK:  if (hs) nstate = ST_SYNC;
      ST_SYNC: if (hs) nstate = ST_PID;
      ST_PID: if (hs) begin
        if (cmd_tx != '0)      nstate = ST_TXD;
        else if (cmd_rx != '0) nstate = ST_RXD;
        else begin ev[F_DONE] = 1'b1; nstate = ST_IDLE; end
      end
      ST_TXD: if (hs) begin
        nsum = lin_cks_add(sum, txf_data);
        ncnt = cnt + 4'd1;
        if (cnt + 4'd1 == cmd_tx) nstate = ST_TXC;
      end
      ST_TXC: if (hs) begin ev[F_DONE] = 1'b1; nstate = ST_IDLE; end
      ST_RXD: if (ser_rx_valid) begin
        nsum = lin_cks_add(sum, ser_rx_data);
        ncnt = cnt + 4'd1;
        if (cnt + 4'd1 == cmd_rx) nstate = ST_RXC;
      end
      ST_RXC: if (ser_rx_valid) begin
        if (ser_rx_data == ~sum) ev[F_CKPASS] = 1'b1;
        else                     ev[F_CKERR]  = 1'b1;
        nstate = ST_IDLE;
      end
      ST_SSYNC: if (ser_rx_valid) nstate = (ser_rx_data == SYNC_BYTE) ? ST_SPID : ST_IDLE;
      ST_SPID: if (ser_rx_valid) begin
        if (lin_pid(ser_rx_data[5:0]) == ser_rx_data) begin
          ev[F_IDPASS] = 1'b1; nrx_id = ser_rx_data[5:0];
        end else ev[F_IDERR] = 1'b1;
        nstate = ST_IDLE;
      end
      default: nstate = ST_IDLE;
    endcase
    if (state != ST_IDLE && nstate != ST_IDLE && cfg_timeout != '0 &&
        tmr == cfg_timeout - TO_W'(1)) begin
      ev[F_ABORT] = 1'b1;
      nstate = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; sum <= '0; cnt <= '0; pid <= '0;
      cmd_tx <= '0; cmd_rx <= '0; tmr <= '0; rx_id <= '0;
    end else if (soft_rst) begin
      state <= ST_IDLE; sum <= '0; cnt <= '0; pid <= '0;
      cmd_tx <= '0; cmd_rx <= '0; tmr <= '0; rx_id <= '0;
    end else begin
      state <= nstate; sum <= nsum; cnt <= ncnt; pid <= npid;
      cmd_tx <= ncmd_tx; cmd_rx <= ncmd_rx; tmr <= ntmr; rx_id <= nrx_id;
    end
  end

  assert_pid_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PID && ser_tx_valid) |->
      (ser_tx_data[6] == (ser_tx_data[0] ^ ser_tx_data[1] ^ ser_tx_data[2] ^ ser_tx_data[4])) &&
      (ser_tx_data[7] != (ser_tx_data[1] ^ ser_tx_data[3] ^ ser_tx_data[4] ^ ser_tx_data[5])));
  assert_reject_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && doorbell && cmd_bad && !soft_rst) |=> !ser_tx_valid);
  assert_brk_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_brk |-> (ser_tx_data >= 8'(MIN_BRK)));
  assert_cks_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev[F_CKPASS] && ev[F_CKERR]));
  assert_rx_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_valid |-> rxf_ready);
  assert_done_abort_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev[F_DONE] && ev[F_ABORT]));
endmodule

// File: rtl/lin_cmd_engine.sv
module lin_cmd_engine
  import lin_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TO_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_master,
  input  logic             cfg_enhanced,
  input  logic [5:0]       cfg_id,
  input  logic [3:0]       cfg_tx_cnt,
  input  logic [3:0]       cfg_rx_cnt,
  input  logic [4:0]       cfg_brk_len,
  input  logic [TO_W-1:0]  cfg_timeout,
  input  logic             doorbell,
  input  logic             tx_fifo_clr,
  input  logic             rx_fifo_clr,
  input  logic             txq_valid,
  output logic             txq_ready,
  input  logic [7:0]       txq_data,
  output logic             rxq_valid,
  input  logic             rxq_ready,
  output logic [7:0]       rxq_data,
  output logic             ser_tx_valid,
  input  logic             ser_tx_ready,
  output logic             ser_tx_brk,
  output logic [7:0]       ser_tx_data,
  input  logic             ser_rx_valid,
  input  logic             ser_rx_brk,
  input  logic [7:0]       ser_rx_data,
  input  logic [NFLAG-1:0] irq_en,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic [5:0]       rx_id
);
  logic             txf_valid, txf_ready, rxf_valid, rxf_ready;
  logic [7:0]       txf_data, rxf_data;
  logic [NFLAG-1:0] ev;

  lin_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_fifo_clr | soft_rst),
    .in_valid(txq_valid), .in_ready(txq_ready), .in_data(txq_data),
    .out_valid(txf_valid), .out_ready(txf_ready), .out_data(txf_data));

  lin_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_fifo_clr | soft_rst),
    .in_valid(rxf_valid), .in_ready(rxf_ready), .in_data(rxf_data),
    .out_valid(rxq_valid), .out_ready(rxq_ready), .out_data(rxq_data));

  lin_frame_fsm #(.TO_W(TO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_master(cfg_master), .cfg_enhanced(cfg_enhanced), .cfg_id(cfg_id),
    .cfg_tx_cnt(cfg_tx_cnt), .cfg_rx_cnt(cfg_rx_cnt), .cfg_brk_len(cfg_brk_len),
    .cfg_timeout(cfg_timeout), .doorbell(doorbell),
    .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_data(txf_data),
    .rxf_valid(rxf_valid), .rxf_ready(rxf_ready), .rxf_data(rxf_data),
    .ser_tx_valid(ser_tx_valid), .ser_tx_ready(ser_tx_ready),
    .ser_tx_brk(ser_tx_brk), .ser_tx_data(ser_tx_data),
    .ser_rx_valid(ser_rx_valid), .ser_rx_brk(ser_rx_brk), .ser_rx_data(ser_rx_data),
    .rx_id(rx_id), .ev(ev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (soft_rst) flags <= '0;
    else               flags <= (flags & ~flag_clr) | ev;
  end

  assign irq = |(flags & irq_en);

  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
endmodule

// File: tb/tb_lin_cmd_engine.sv
module tb_lin_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic cfg_master = 1'b1, cfg_enhanced = 1'b0;
  logic [5:0] cfg_id = '0;
  logic [3:0] cfg_tx_cnt = '0, cfg_rx_cnt = '0;
  logic [4:0] cfg_brk_len = 5'd13;
  logic [15:0] cfg_timeout = '0;
  logic doorbell = 1'b0, tx_fifo_clr = 1'b0, rx_fifo_clr = 1'b0;
  logic txq_valid = 1'b0, txq_ready;
  logic [7:0] txq_data = '0;
  logic rxq_valid, rxq_ready = 1'b0;
  logic [7:0] rxq_data;
  logic ser_tx_valid, ser_tx_ready = 1'b1, ser_tx_brk;
  logic [7:0] ser_tx_data;
  logic ser_rx_valid = 1'b0, ser_rx_brk = 1'b0;
  logic [7:0] ser_rx_data = '0;
  logic [6:0] irq_en = 7'h7F, flag_clr = '0, flags;
  logic irq;
  logic [5:0] rx_id;

  int vectors = 0, miscompares = 0;
  bit stall = 1'b0, finished = 1'b0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  lin_cmd_engine dut (.*);

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pid(input logic [5:0] id);
    logic [7:0] r;
    r = {2'b00, id};
    r[6] = id[0] ^ id[1] ^ id[2] ^ id[4];
    r[7] = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return r;
  endfunction

  function automatic logic [7:0] ref_cks(input logic [7:0] seed, input logic [7:0] d[$]);
    int s = seed;
    foreach (d[i]) begin
      s = s + d[i];
      if (s > 255) s = s - 255;
    end
    return ~(8'(s));
  endfunction

  // serialiser model: compares every accepted symbol with the expected stream
  always @(negedge clk) begin
    ser_tx_ready = !stall;
    if (rst_n && ser_tx_valid && ser_tx_ready) begin
      if (exp_q.size() == 0) chk("unexpected symbol R2", {ser_tx_brk, ser_tx_data}, 0);
      else chk("tx stream R3/R4", {ser_tx_brk, ser_tx_data}, exp_q.pop_front());
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic push_tx(logic [7:0] b);
    bit done = 0;
    txq_valid = 1'b1; txq_data = b;
    while (!done) begin done = txq_ready; @(negedge clk); end
    txq_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    rxq_ready = 1'b1;
    while (!rxq_valid) @(negedge clk);
    b = rxq_data;
    @(negedge clk);
    rxq_ready = 1'b0;
  endtask

  task automatic rx_byte(logic [7:0] b);
    ser_rx_valid = 1'b1; ser_rx_data = b; @(negedge clk);
    ser_rx_valid = 1'b0; cyc(2);
  endtask

  task automatic rx_break();
    ser_rx_brk = 1'b1; @(negedge clk); ser_rx_brk = 1'b0; cyc(2);
  endtask

  task automatic ring(logic [3:0] t, logic [3:0] r);
    cfg_tx_cnt = t; cfg_rx_cnt = r; doorbell = 1'b1; @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic wait_flag(int bitn);
    int n = 0;
    while (!flags[bitn] && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_q();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    cyc(2);
  endtask

  task automatic clear_flags();
    flag_clr = 7'h7F; @(negedge clk); flag_clr = '0;
  endtask

  task automatic exp_hdr(logic [5:0] id, int brk);
    exp_q.push_back({1'b1, 8'(brk)});
    exp_q.push_back({1'b0, 8'h55});
    exp_q.push_back({1'b0, ref_pid(id)});
  endtask

  task automatic master_tx(logic [5:0] id, bit enh, logic [7:0] d[$], int brk);
    logic [7:0] seed;
    logic [7:0] cks;
    cfg_id = id; cfg_enhanced = enh;
    seed = (enh && id != 6'h3C && id != 6'h3D) ? ref_pid(id) : 8'h00;
    cks = ref_cks(seed, d);
    exp_hdr(id, brk);
    foreach (d[i]) begin push_tx(d[i]); exp_q.push_back({1'b0, d[i]}); end
    exp_q.push_back({1'b0, cks});
    ring(4'(d.size()), 4'd0);
    wait_flag(0);
  endtask

  initial begin
    logic [7:0] d[$];
    logic [7:0] b;
    logic [7:0] pid1a;
    pid1a = ref_pid(6'h1A);
    cyc(3); rst_n = 1'b1; cyc(2);

    // reset state
    chk("reset flags R11", flags, 0);
    chk("reset irq R11", irq, 0);
    chk("reset tx idle R3", ser_tx_valid, 0);
    chk("reset txq ready R14", txq_ready, 1);
    chk("reset rxq empty R12", rxq_valid, 0);

    // R4 R1 R3: classic master transmit
    d = '{8'h12, 8'h34, 8'hF0};
    cfg_brk_len = 5'd13;
    master_tx(6'h10, 1'b0, d, 13);
    cyc(2);
    chk("R4 done flag", flags, 7'h01);
    chk("R4 stream consumed", exp_q.size(), 0);
    chk("R11 irq on done", irq, 1);
    clear_flags();
    chk("R11 flags cleared", flags, 0);

    // R5 R3: enhanced checksum, short break clamped
    d = '{8'hFF, 8'h80};
    cfg_brk_len = 5'd5;
    master_tx(6'h23, 1'b1, d, 13);
    cyc(2);
    chk("R5 enhanced done", flags, 7'h01);
    chk("R5 stream consumed", exp_q.size(), 0);
    clear_flags();

    // R5: sleep ID forces classic, 8 bytes, long break
    d = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    cfg_brk_len = 5'd20;
    master_tx(6'h3C, 1'b1, d, 20);
    cyc(2);
    chk("R5 sleep id classic", flags, 7'h01);
    chk("R5 sleep stream consumed", exp_q.size(), 0);
    clear_flags();
    cfg_brk_len = 5'd13;

    // R2: rejects
    ring(4'd9, 4'd0); cyc(4);
    chk("R2 count over 8", flags, 7'h40);
    clear_flags();
    ring(4'd2, 4'd3); cyc(4);
    chk("R2 both counts", flags, 7'h40);
    chk("R2 nothing sent", ser_tx_valid, 0);
    clear_flags();

    // R13: header only
    cfg_id = 6'h3D; cfg_enhanced = 1'b0;
    exp_hdr(6'h3D, 13);
    ring(4'd0, 4'd0);
    wait_flag(0); cyc(1);
    chk("R13 header only done", flags, 7'h01);
    chk("R13 stream consumed", exp_q.size(), 0);
    clear_flags();

    // R6: master receive, good then bad checksum
    cfg_id = 6'h05; cfg_enhanced = 1'b1;
    exp_hdr(6'h05, 13);
    ring(4'd0, 4'd2);
    wait_q();
    d = '{8'hA5, 8'h5A};
    rx_byte(8'hA5); rx_byte(8'h5A); rx_byte(ref_cks(ref_pid(6'h05), d));
    chk("R6 checksum pass", flags, 7'h04);
    pop_rx(b); chk("R6 rx byte 0", b, 8'hA5);
    pop_rx(b); chk("R6 rx byte 1", b, 8'h5A);
    clear_flags();
    exp_hdr(6'h05, 13);
    ring(4'd0, 4'd2);
    wait_q();
    rx_byte(8'h01); rx_byte(8'h02); rx_byte(8'h00);
    chk("R6 checksum error", flags, 7'h08);
    chk("R6 bytes kept", rxq_valid, 1);
    rx_fifo_clr = 1'b1; @(negedge clk); rx_fifo_clr = 1'b0; cyc(1);
    chk("R12 rx queue cleared", rxq_valid, 0);
    clear_flags();

    // R7: timeout abort with stalled serialiser
    stall = 1'b1; cfg_timeout = 16'd20; cfg_id = 6'h11; cfg_enhanced = 1'b0;
    ring(4'd1, 4'd0);
    cyc(30);
    chk("R7 abort flag", flags, 7'h02);
    stall = 1'b0; cyc(2);
    chk("R7 idle after abort", ser_tx_valid, 0);
    cfg_timeout = '0;
    clear_flags();

    // R9: master ignores received header
    rx_break(); rx_byte(8'h55); rx_byte(pid1a);
    chk("R9 master ignores break", flags, 0);

    // R8: slave header detection
    cfg_master = 1'b0; cyc(1);
    rx_break(); rx_byte(8'h55); rx_byte(pid1a);
    chk("R8 pid pass", flags, 7'h10);
    chk("R8 id latched", rx_id, 6'h1A);
    clear_flags();
    rx_break(); rx_byte(8'h55); rx_byte(pid1a ^ 8'h80);
    chk("R8 pid error", flags, 7'h20);
    chk("R8 id kept", rx_id, 6'h1A);
    clear_flags();
    rx_break(); rx_byte(8'h54); rx_byte(pid1a);
    chk("R8 bad sync silent", flags, 0);

    // R10: slave response, no header, enhanced with held id
    cfg_enhanced = 1'b1; cfg_id = 6'h00;
    d = '{8'h33, 8'hC4};
    push_tx(8'h33); push_tx(8'hC4);
    exp_q.push_back({1'b0, 8'h33});
    exp_q.push_back({1'b0, 8'hC4});
    exp_q.push_back({1'b0, ref_cks(pid1a, d)});
    ring(4'd2, 4'd0);
    wait_flag(0); cyc(1);
    chk("R10 slave response done", flags, 7'h01);
    chk("R10 stream consumed", exp_q.size(), 0);

    // R11: interrupt enable gating
    irq_en = 7'h7E; cyc(1);
    chk("R11 masked irq", irq, 0);
    irq_en = 7'h01; cyc(1);
    chk("R11 enabled irq", irq, 1);
    irq_en = 7'h7F;

    // R12: soft reset clears flags
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0; cyc(1);
    chk("R12 soft reset flags", flags, 0);

    // R14 R12: transmit queue full, then cleared
    cfg_master = 1'b1;
    for (int i = 0; i < 8; i++) push_tx(8'(i));
    cyc(1);
    chk("R14 queue full", txq_ready, 0);
    tx_fifo_clr = 1'b1; @(negedge clk); tx_fifo_clr = 1'b0; cyc(1);
    chk("R12 tx queue cleared", txq_ready, 1);

    cyc(5);
    chk("final flags R11", flags, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule